// File: doc/BRIEF.md
# Dynamic Non-Uniform Cache Bank-Set Controller

This controller serves lookups in one group of cache banks (a bank set) of a large, physically spread last-level cache. Each request carries a byte address. The controller decodes a bank-set number and a line index from the address and probes the banks of that set. Bank position 0 is the home bank, the one nearest the requester, and higher positions lie farther away. The probe order is chosen per request: one bank per step outward from home, a pair of banks per step, or every bank at once.

On a hit the line is returned and moved one position closer to home, where it trades places with whatever that bank held. On a miss the controller fetches the line from the next memory level and places it in either the nearest or the farthest bank. The line it displaces is either pushed one position outward or written back to the next level. Each bank holds one line per index. The banks are external storage reached through a registered read port (data one cycle after the enable) and a write port, selected by the bank-set and index outputs.

Top module: `dnuca_bankset_ctrl`

## Requirements
- R1: The address is split from the top down as tag (remaining bits), bank-set number (BSW bits), line index (IDXW bits) and byte offset (OFFW bits). All bank reads and writes of a request use that bank-set number on `bk_set` and that index on `bk_idx`.
- R2: With `req_mode` = 00 (sequential), step k probes only bank position k. The search stops at the first hit, and no farther bank is read. `resp_lat` reports the number of steps used.
- R3: With `req_mode` = 01 (paired), step k probes positions 2k and 2k+1 together. A hit found in step k reports `resp_lat` = k+1.
- R4: With `req_mode` = 10 or 11 (broadcast), every position is probed in a single step and `resp_lat` is 1.
- R5: A hit at position h > 0 returns `resp_hit`=1 with the stored data. Position h-1 then holds the hit line. Position h then holds the former content of h-1, which leaves h empty if h-1 was empty.
- R6: A hit at the home position (0) writes no bank.
- R7: When no probed bank holds the tag, one `mem_req_valid` pulse is issued with the line address (offset bits zero). The response carries `resp_hit`=0, the data returned by the next level, and `resp_lat` equal to the full step count of the mode (NB, NB/2 or 1).
- R8: A miss fill is written valid into position 0 when `cfg_fill_far`=0, and into position NB-1 when `cfg_fill_far`=1.
- R9: A valid line displaced by a fill is written to position 1 only if `cfg_demote`=1, the fill went to position 0 and position 1 was empty. In every other case it leaves through one `mem_wb_valid` pulse with its own line address and data.
- R10: `req_ready` is high only while idle. `busy` is high from the cycle after acceptance through the response cycle, and `resp_valid` is a one-cycle pulse.
- R11: After reset, `busy`=0, `req_ready`=1, and no response, bank enable or memory request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken |
| req_addr | input | AW | Request byte address |
| req_mode | input | 2 | Probe order: 00 sequential, 01 paired, 1x broadcast |
| cfg_fill_far | input | 1 | Miss fill goes to farthest bank |
| cfg_demote | input | 1 | Displaced line may move one bank outward |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Response was a hit |
| resp_data | output | DW | Line data returned |
| resp_lat | output | $clog2(NB)+1 | Probe steps used |
| busy | output | 1 | Request in progress |
| bk_set | output | BSW | Bank-set number for bank accesses |
| bk_idx | output | IDXW | Line index for bank accesses |
| bk_rd_en | output | NB | Read enable per bank position |
| bk_rd_valid | input | NB | Read valid bit per position, one cycle after enable |
| bk_rd_tag | input | NB*TW | Read tags, position p at bits p*TW |
| bk_rd_data | input | NB*DW | Read data, position p at bits p*DW |
| bk_wr_en | output | NB | Write enable per position |
| bk_wr_valid | output | NB | Valid bit written per position |
| bk_wr_tag | output | NB*TW | Tag written per position |
| bk_wr_data | output | NB*DW | Data written per position |
| mem_req_valid | output | 1 | Line fetch request pulse |
| mem_req_addr | output | AW | Line address of fetch |
| mem_resp_valid | input | 1 | Fetched line returned |
| mem_resp_data | input | DW | Fetched line data |
| mem_wb_valid | output | 1 | Writeback pulse |
| mem_wb_addr | output | AW | Line address of written-back line |
| mem_wb_data | output | DW | Data of written-back line |

## Verification
The bench uses the defaults: a 16-bit address, a 10-bit tag, two bank sets of four positions, eight indexes and 16-bit data. With four positions, the paired mode has two distinct steps and the sequential mode has a depth where stopping early can be seen (position 3 left unread). With two bank sets, the bench can show that a lookup reads and migrates only within the selected set. The four positions also let every fill and victim case occur: fill near or far, a demote into an empty position 1, a demote blocked by an occupied position 1, and a writeback from the farthest position.

// File: rtl/dnuca_pkg.sv
package dnuca_pkg;

  typedef enum logic [1:0] {
    SRCH_SEQ  = 2'b00,
    SRCH_PAIR = 2'b01,
    SRCH_ALL  = 2'b10
  } search_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROBE,
    S_CHECK,
    S_HIT,
    S_MREQ,
    S_MWAIT,
    S_FILL
  } state_e;

  // number of probe steps a full search takes in a given mode
  function automatic int unsigned steps_needed(input logic [1:0] mode, input int unsigned nb);
    if (mode == SRCH_SEQ)       return nb;
    else if (mode == SRCH_PAIR) return (nb + 1) / 2;
    else                        return 1;
  endfunction

endpackage

// File: rtl/dnuca_addr_split.sv
module dnuca_addr_split #(
  parameter int AW   = 16,
  parameter int OFFW = 2,
  parameter int IDXW = 3,
  parameter int BSW  = 1,
  localparam int TW  = AW - OFFW - IDXW - BSW
) (
  input  logic [AW-1:0]   addr,
  output logic [TW-1:0]   tag,
  output logic [BSW-1:0]  bset,
  output logic [IDXW-1:0] idx
);
  assign idx  = addr[OFFW +: IDXW];
  assign bset = addr[OFFW+IDXW +: BSW];
  assign tag  = addr[AW-1 -: TW];
endmodule

// File: rtl/dnuca_probe_sched.sv
module dnuca_probe_sched
  import dnuca_pkg::*;
#(
  parameter int NB   = 4,
  parameter int LATW = 3
) (
  input  logic [1:0]      mode,
  input  logic [LATW-1:0] step,
  output logic [NB-1:0]   mask,
  output logic            last
);
  localparam int STEPS_SEQ  = NB;
  localparam int STEPS_PAIR = (NB + 1) / 2;

  for (genvar b = 0; b < NB; b++) begin : g_pos
    assign mask[b] = (mode == SRCH_SEQ)  ? (step == LATW'(b)) :
                     (mode == SRCH_PAIR) ? (step == LATW'(b / 2)) :
                                           1'b1;
  end

  assign last = (step == LATW'(steps_needed(mode, NB) - 1));
endmodule

// File: rtl/dnuca_hit_pick.sv
module dnuca_hit_pick #(
  parameter int NB = 4,
  parameter int TW = 10,
  parameter int PW = 2
) (
  input  logic [NB-1:0]    mask,
  input  logic [NB-1:0]    rd_valid,
  input  logic [NB*TW-1:0] rd_tag,
  input  logic [TW-1:0]    tag,
  output logic             any_hit,
  output logic [PW-1:0]    hit_pos
);
  logic [NB-1:0] match;

  for (genvar b = 0; b < NB; b++) begin : g_cmp
    assign match[b] = mask[b] & rd_valid[b] & (rd_tag[b*TW +: TW] == tag);
  end

  // nearest matching position wins
  always_comb begin
    hit_pos = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (match[b]) hit_pos = PW'(b);
    end
  end

  assign any_hit = |match;
endmodule

// File: rtl/dnuca_bankset_ctrl.sv
module dnuca_bankset_ctrl
  import dnuca_pkg::*;
#(
  parameter int AW   = 16,
  parameter int OFFW = 2,
  parameter int IDXW = 3,
  parameter int BSW  = 1,
  parameter int NB   = 4,
  parameter int DW   = 16,
  localparam int TW   = AW - OFFW - IDXW - BSW,
  localparam int PW   = $clog2(NB),
  localparam int LATW = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_mode,
  input  logic             cfg_fill_far,
  input  logic             cfg_demote,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [DW-1:0]    resp_data,
  output logic [LATW-1:0]  resp_lat,
  output logic             busy,
  output logic [BSW-1:0]   bk_set,
  output logic [IDXW-1:0]  bk_idx,
  output logic [NB-1:0]    bk_rd_en,
  input  logic [NB-1:0]    bk_rd_valid,
  input  logic [NB*TW-1:0] bk_rd_tag,
  input  logic [NB*DW-1:0] bk_rd_data,
  output logic [NB-1:0]    bk_wr_en,
  output logic [NB-1:0]    bk_wr_valid,
  output logic [NB*TW-1:0] bk_wr_tag,
  output logic [NB*DW-1:0] bk_wr_data,
  output logic             mem_req_valid,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_resp_valid,
  input  logic [DW-1:0]    mem_resp_data,
  output logic             mem_wb_valid,
  output logic [AW-1:0]    mem_wb_addr,
  output logic [DW-1:0]    mem_wb_data
);

  // ---------------- address decode of the incoming request
  logic [TW-1:0]   in_tag;
  logic [BSW-1:0]  in_bs;
  logic [IDXW-1:0] in_idx;

  dnuca_addr_split #(.AW(AW), .OFFW(OFFW), .IDXW(IDXW), .BSW(BSW)) u_split (
    .addr (req_addr),
    .tag  (in_tag),
    .bset (in_bs),
    .idx  (in_idx)
  );

  // ---------------- request state
  state_e          state;
  logic [TW-1:0]   a_tag;
  logic [BSW-1:0]  a_bs;
  logic [IDXW-1:0] a_idx;
  logic [1:0]      a_mode;
  logic            a_far;
  logic            a_dem;
  logic [LATW-1:0] step;
  logic [LATW-1:0] lat_q;
  logic [PW-1:0]   hit_pos_q;
  logic [DW-1:0]   fill_data_q;

  // copy of every bank line read during this request
  logic            snap_v    [NB];
  logic [TW-1:0]   snap_tag  [NB];
  logic [DW-1:0]   snap_data [NB];

  // ---------------- probe schedule and tag compare
  logic [NB-1:0] probe_mask;
  logic          probe_last;
  logic          any_hit;
  logic [PW-1:0] hit_pos;

  dnuca_probe_sched #(.NB(NB), .LATW(LATW)) u_sched (
    .mode (a_mode),
    .step (step),
    .mask (probe_mask),
    .last (probe_last)
  );

  dnuca_hit_pick #(.NB(NB), .TW(TW), .PW(PW)) u_pick (
    .mask     (probe_mask),
    .rd_valid (bk_rd_valid),
    .rd_tag   (bk_rd_tag),
    .tag      (a_tag),
    .any_hit  (any_hit),
    .hit_pos  (hit_pos)
  );

  // ---------------- placement arithmetic
  function automatic logic [PW-1:0] nearer_pos(input logic [PW-1:0] p);
    return p - PW'(1);
  endfunction

  function automatic logic [PW-1:0] fill_target(input logic far);
    return far ? PW'(NB - 1) : '0;
  endfunction

  function automatic logic [AW-1:0] line_addr(input logic [TW-1:0] t,
                                              input logic [BSW-1:0] s,
                                              input logic [IDXW-1:0] i);
    return {t, s, i, {OFFW{1'b0}}};
  endfunction

  // ---------------- named internal events
  logic          ev_hit;     // tag match seen in the compare cycle
  logic          ev_miss;    // last step compared without a match
  logic          ev_swap;    // hit line migrates toward home
  logic          ev_victim;  // fill displaces a valid line
  logic          ev_demote;  // displaced line moves one bank outward
  logic          ev_wb;      // displaced line leaves to next level
  logic [PW-1:0] fill_pos;

  assign fill_pos  = fill_target(a_far);
  assign ev_hit    = (state == S_CHECK) && any_hit;
  assign ev_miss   = (state == S_CHECK) && !any_hit && probe_last;
  assign ev_swap   = (state == S_HIT) && (hit_pos_q != '0);
  assign ev_victim = (state == S_FILL) && snap_v[fill_pos];
  assign ev_demote = ev_victim && a_dem && !a_far && !snap_v[1];
  assign ev_wb     = ev_victim && !ev_demote;

  // ---------------- sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      a_tag       <= '0;
      a_bs        <= '0;
      a_idx       <= '0;
      a_mode      <= SRCH_SEQ;
      a_far       <= 1'b0;
      a_dem       <= 1'b0;
      step        <= '0;
      lat_q       <= '0;
      hit_pos_q   <= '0;
      fill_data_q <= '0;
      for (int b = 0; b < NB; b++) begin
        snap_v[b]    <= 1'b0;
        snap_tag[b]  <= '0;
        snap_data[b] <= '0;
      end
    end else begin
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            a_tag  <= in_tag;
            a_bs   <= in_bs;
            a_idx  <= in_idx;
            a_mode <= req_mode;
            a_far  <= cfg_fill_far;
            a_dem  <= cfg_demote;
            step   <= '0;
            state  <= S_PROBE;
          end
        end
        S_PROBE: state <= S_CHECK;
        S_CHECK: begin
          for (int b = 0; b < NB; b++) begin
            if (probe_mask[b]) begin
              snap_v[b]    <= bk_rd_valid[b];
              snap_tag[b]  <= bk_rd_tag[b*TW +: TW];
              snap_data[b] <= bk_rd_data[b*DW +: DW];
            end
          end
          lat_q <= step + LATW'(1);
          if (any_hit) begin
            hit_pos_q <= hit_pos;
            state     <= S_HIT;
          end else if (probe_last) begin
            state <= S_MREQ;
          end else begin
            step  <= step + LATW'(1);
            state <= S_PROBE;
          end
        end
        S_HIT:  state <= S_IDLE;
        S_MREQ: state <= S_MWAIT;
        S_MWAIT: begin
          if (mem_resp_valid) begin
            fill_data_q <= mem_resp_data;
            state       <= S_FILL;
          end
        end
        S_FILL:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- bank write port
  logic          wv [NB];
  logic [TW-1:0] wt [NB];
  logic [DW-1:0] wd [NB];

  always_comb begin
    bk_wr_en = '0;
    for (int b = 0; b < NB; b++) begin
      wv[b] = 1'b0;
      wt[b] = '0;
      wd[b] = '0;
    end
    if (ev_swap) begin
      bk_wr_en[nearer_pos(hit_pos_q)] = 1'b1;
      wv[nearer_pos(hit_pos_q)]       = 1'b1;
      wt[nearer_pos(hit_pos_q)]       = snap_tag[hit_pos_q];
      wd[nearer_pos(hit_pos_q)]       = snap_data[hit_pos_q];
      bk_wr_en[hit_pos_q]             = 1'b1;
      wv[hit_pos_q]                   = snap_v[nearer_pos(hit_pos_q)];
      wt[hit_pos_q]                   = snap_tag[nearer_pos(hit_pos_q)];
      wd[hit_pos_q]                   = snap_data[nearer_pos(hit_pos_q)];
    end
    if (state == S_FILL) begin
      bk_wr_en[fill_pos] = 1'b1;
      wv[fill_pos]       = 1'b1;
      wt[fill_pos]       = a_tag;
      wd[fill_pos]       = fill_data_q;
      if (ev_demote) begin
        bk_wr_en[1] = 1'b1;
        wv[1]       = 1'b1;
        wt[1]       = snap_tag[fill_pos];
        wd[1]       = snap_data[fill_pos];
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_wpack
    assign bk_wr_valid[b]         = wv[b];
    assign bk_wr_tag[b*TW +: TW]  = wt[b];
    assign bk_wr_data[b*DW +: DW] = wd[b];
  end

  // ---------------- outputs
  assign req_ready     = (state == S_IDLE);
  assign busy          = (state != S_IDLE);
  assign bk_set        = a_bs;
  assign bk_idx        = a_idx;
  assign bk_rd_en      = (state == S_PROBE) ? probe_mask : '0;
  assign resp_valid    = (state == S_HIT) || (state == S_FILL);
  assign resp_hit      = (state == S_HIT);
  assign resp_data     = (state == S_HIT) ? snap_data[hit_pos_q] : fill_data_q;
  assign resp_lat      = lat_q;
  assign mem_req_valid = (state == S_MREQ);
  assign mem_req_addr  = line_addr(a_tag, a_bs, a_idx);
  assign mem_wb_valid  = ev_wb;
  assign mem_wb_addr   = line_addr(snap_tag[fill_pos], a_bs, a_idx);
  assign mem_wb_data   = snap_data[fill_pos];

  // ---------------- assertions
  a_r2_seq_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROBE && a_mode == SRCH_SEQ) |-> ($countones(bk_rd_en) == 1));

  a_r2_stop_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (bk_rd_en == '0));

  a_r3_pair_width: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROBE && a_mode == SRCH_PAIR) |-> ($countones(bk_rd_en) == 2));

  a_r4_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROBE && a_mode[1]) |-> (&bk_rd_en));

  a_r5_swap_two_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit && hit_pos_q != '0) |-> ($countones(bk_wr_en) == 2));

  a_r6_home_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit && hit_pos_q == '0) |-> (bk_wr_en == '0));

  a_r7_fetch_inside_miss: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (busy && !resp_valid && bk_rd_en == '0));

  a_r7_miss_after_full_search: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> mem_req_valid);

  a_r9_wb_with_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb_valid |-> (resp_valid && !resp_hit && bk_wr_en[fill_pos]));

  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

endmodule

// File: tb/dnuca_bankset_ctrl_test.sv
module dnuca_bankset_ctrl_test;
  localparam int AW = 16, OFFW = 2, IDXW = 3, BSW = 1, NB = 4, DW = 16;
  localparam int TW = AW - OFFW - IDXW - BSW;
  localparam int LATW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             req_valid = 1'b0, req_ready;
  logic [AW-1:0]    req_addr = '0;
  logic [1:0]       req_mode = 2'b00;
  logic             cfg_fill_far = 1'b0, cfg_demote = 1'b0;
  logic             resp_valid, resp_hit, busy;
  logic [DW-1:0]    resp_data;
  logic [LATW-1:0]  resp_lat;
  logic [BSW-1:0]   bk_set;
  logic [IDXW-1:0]  bk_idx;
  logic [NB-1:0]    bk_rd_en, bk_wr_en, bk_wr_valid;
  logic [NB-1:0]    bk_rd_valid = '0;
  logic [NB*TW-1:0] bk_rd_tag = '0, bk_wr_tag;
  logic [NB*DW-1:0] bk_rd_data = '0, bk_wr_data;
  logic             mem_req_valid, mem_wb_valid;
  logic [AW-1:0]    mem_req_addr, mem_wb_addr;
  logic             mem_resp_valid = 1'b0;
  logic [DW-1:0]    mem_resp_data = '0, mem_wb_data;

  dnuca_bankset_ctrl uut (.*);

  // ---------------- behavioural bank storage: [bank set][position][index]
  logic          bv [2][NB][8];
  logic [TW-1:0] bt [2][NB][8];
  logic [DW-1:0] bd [2][NB][8];

  int rd_cnt [NB];
  int wr_cnt, wb_cnt, mreq_cnt;
  logic [AW-1:0] wb_addr_seen, mreq_addr_seen;
  logic [DW-1:0] wb_data_seen;
  logic [BSW-1:0] set_seen;

  initial begin
    for (int b = 0; b < NB; b++) rd_cnt[b] = 0;
    wr_cnt = 0; wb_cnt = 0; mreq_cnt = 0;
  end

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (bk_rd_en[b]) begin
        bk_rd_valid[b]         <= bv[bk_set][b][bk_idx];
        bk_rd_tag[b*TW +: TW]  <= bt[bk_set][b][bk_idx];
        bk_rd_data[b*DW +: DW] <= bd[bk_set][b][bk_idx];
        rd_cnt[b]              <= rd_cnt[b] + 1;
        set_seen               <= bk_set;
      end
      if (bk_wr_en[b]) begin
        bv[bk_set][b][bk_idx] <= bk_wr_valid[b];
        bt[bk_set][b][bk_idx] <= bk_wr_tag[b*TW +: TW];
        bd[bk_set][b][bk_idx] <= bk_wr_data[b*DW +: DW];
      end
    end
    wr_cnt <= wr_cnt + $countones(bk_wr_en);
    if (mem_wb_valid) begin
      wb_cnt       <= wb_cnt + 1;
      wb_addr_seen <= mem_wb_addr;
      wb_data_seen <= mem_wb_data;
    end
  end

  // ---------------- next-level stub: answers three cycles after a request
  int stub_wait = 0;
  function automatic logic [DW-1:0] stub_data(input logic [AW-1:0] a);
    return a ^ 16'h3C96;
  endfunction

  always @(posedge clk) begin
    mem_resp_valid <= 1'b0;
    if (mem_req_valid) begin
      mreq_cnt       <= mreq_cnt + 1;
      mreq_addr_seen <= mem_req_addr;
      mem_resp_data  <= stub_data(mem_req_addr);
      stub_wait      <= 3;
    end else if (stub_wait > 0) begin
      stub_wait <= stub_wait - 1;
      if (stub_wait == 1) mem_resp_valid <= 1'b1;
    end
  end

  // ---------------- scoring
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input logic [TW-1:0] t, input logic s, input logic [2:0] i);
    return {t, s, i, 2'b10};
  endfunction

  function automatic logic [AW-1:0] line_of(input logic [TW-1:0] t, input logic s, input logic [2:0] i);
    return {t, s, i, 2'b00};
  endfunction

  task automatic clear_banks();
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < 8; i++) begin
          bv[s][b][i] = 1'b0; bt[s][b][i] = '0; bd[s][b][i] = '0;
        end
  endtask

  task automatic put(input int s, input int p, input int i, input logic [TW-1:0] t, input logic [DW-1:0] d);
    bv[s][p][i] = 1'b1; bt[s][p][i] = t; bd[s][p][i] = d;
  endtask

  task automatic expect_line(input string what, input int s, input int p, input int i,
                             input logic v, input logic [TW-1:0] t, input logic [DW-1:0] d);
    chk({what, " valid"}, 32'(bv[s][p][i]), 32'(v));
    if (v) begin
      chk({what, " tag"},  32'(bt[s][p][i]), 32'(t));
      chk({what, " data"}, 32'(bd[s][p][i]), 32'(d));
    end
  endtask

  // results of the last request
  logic r_hit;
  logic [DW-1:0] r_data;
  logic [LATW-1:0] r_lat;
  int d_rd [NB];
  int d_wr, d_wb, d_mreq;

  task automatic run(input logic [AW-1:0] a, input logic [1:0] m, input logic far, input logic dem);
    int rd0 [NB];
    int wr0, wb0, mq0, n;
    for (int b = 0; b < NB; b++) rd0[b] = rd_cnt[b];
    wr0 = wr_cnt; wb0 = wb_cnt; mq0 = mreq_cnt;
    @(negedge clk);
    chk("R10 ready while idle", 32'(req_ready), 32'd1);
    req_addr = a; req_mode = m; cfg_fill_far = far; cfg_demote = dem; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy after accept", 32'(busy), 32'd1);
    chk("R10 not ready while busy", 32'(req_ready), 32'd0);
    n = 0;
    while (!resp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R10 response arrives", 32'(resp_valid), 32'd1);
    chk("R10 busy in response cycle", 32'(busy), 32'd1);
    r_hit = resp_hit; r_data = resp_data; r_lat = resp_lat;
    @(negedge clk);
    chk("R10 response is one pulse", 32'(resp_valid), 32'd0);
    chk("R10 idle after response", 32'(busy), 32'd0);
    for (int b = 0; b < NB; b++) d_rd[b] = rd_cnt[b] - rd0[b];
    d_wr = wr_cnt - wr0; d_wb = wb_cnt - wb0; d_mreq = mreq_cnt - mq0;
  endtask

  // ---------------- scenarios
  task automatic t_reset();
    chk("R11 busy low in reset", 32'(busy), 32'd0);
    chk("R11 ready in reset", 32'(req_ready), 32'd1);
    chk("R11 no response", 32'(resp_valid), 32'd0);
    chk("R11 no bank enables", 32'({bk_rd_en, bk_wr_en}), 32'd0);
    chk("R11 no fetch", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_seq_hit_swap();
    clear_banks();
    put(0, 1, 5, 10'h011, 16'hB1B1);
    put(0, 2, 5, 10'h022, 16'hC2C2);
    run(mk(10'h022, 0, 5), 2'b00, 1'b0, 1'b0);
    chk("R5 hit flag", 32'(r_hit), 32'd1);
    chk("R5 hit data", 32'(r_data), 32'hC2C2);
    chk("R2 latency 3 steps", 32'(r_lat), 32'd3);
    chk("R2 pos0 read once", 32'(d_rd[0]), 32'd1);
    chk("R2 pos2 read once", 32'(d_rd[2]), 32'd1);
    chk("R2 pos3 not read after hit", 32'(d_rd[3]), 32'd0);
    expect_line("R5 migrated to pos1", 0, 1, 5, 1'b1, 10'h022, 16'hC2C2);
    expect_line("R5 swapped into pos2", 0, 2, 5, 1'b1, 10'h011, 16'hB1B1);
    chk("R5 no fetch on hit", 32'(d_mreq), 32'd0);
  endtask

  task automatic t_home_hit();
    clear_banks();
    put(0, 0, 3, 10'h033, 16'hD3D3);
    run(mk(10'h033, 0, 3), 2'b00, 1'b0, 1'b0);
    chk("R6 hit", 32'(r_hit), 32'd1);
    chk("R6 data", 32'(r_data), 32'hD3D3);
    chk("R2 home latency", 32'(r_lat), 32'd1);
    chk("R6 no bank writes", 32'(d_wr), 32'd0);
    expect_line("R6 home line kept", 0, 0, 3, 1'b1, 10'h033, 16'hD3D3);
  endtask

  task automatic t_pair_hit_empty();
    clear_banks();
    put(0, 3, 6, 10'h0A3, 16'hE3E3);
    run(mk(10'h0A3, 0, 6), 2'b01, 1'b0, 1'b0);
    chk("R3 hit", 32'(r_hit), 32'd1);
    chk("R3 data", 32'(r_data), 32'hE3E3);
    chk("R3 latency 2 steps", 32'(r_lat), 32'd2);
    chk("R3 reads pos0", 32'(d_rd[0]), 32'd1);
    chk("R3 reads pos1", 32'(d_rd[1]), 32'd1);
    chk("R3 reads pos3", 32'(d_rd[3]), 32'd1);
    expect_line("R5 moved into empty pos2", 0, 2, 6, 1'b1, 10'h0A3, 16'hE3E3);
    expect_line("R5 pos3 left empty", 0, 3, 6, 1'b0, '0, '0);
  endtask

  task automatic t_broadcast_set1();
    clear_banks();
    put(1, 1, 2, 10'h1B1, 16'hF1F1);
    put(0, 1, 2, 10'h1B1, 16'h0BAD);
    run(mk(10'h1B1, 1, 2), 2'b10, 1'b0, 1'b0);
    chk("R4 hit", 32'(r_hit), 32'd1);
    chk("R1 data from selected set", 32'(r_data), 32'hF1F1);
    chk("R4 latency 1", 32'(r_lat), 32'd1);
    chk("R4 all positions read once",
        32'(d_rd[0] + d_rd[1] + d_rd[2] + d_rd[3]), 32'd4);
    chk("R1 bank set driven", 32'(set_seen), 32'd1);
    expect_line("R1 set1 pos0 migrated", 1, 0, 2, 1'b1, 10'h1B1, 16'hF1F1);
    expect_line("R1 set0 pos0 untouched", 0, 0, 2, 1'b0, '0, '0);
    expect_line("R1 set0 pos1 untouched", 0, 1, 2, 1'b1, 10'h1B1, 16'h0BAD);
    run(mk(10'h1B1, 1, 2), 2'b11, 1'b0, 1'b0);
    chk("R4 mode 11 latency", 32'(r_lat), 32'd1);
    chk("R6 mode 11 home hit no writes", 32'(d_wr), 32'd0);
  endtask

  task automatic t_miss_near_empty();
    clear_banks();
    put(0, 2, 4, 10'h0C0, 16'h1111);
    run(mk(10'h0C1, 0, 4), 2'b00, 1'b0, 1'b0);
    chk("R7 miss", 32'(r_hit), 32'd0);
    chk("R7 latency full search", 32'(r_lat), 32'd4);
    chk("R7 one fetch", 32'(d_mreq), 32'd1);
    chk("R7 fetch line address", 32'(mreq_addr_seen), 32'(line_of(10'h0C1, 0, 4)));
    chk("R7 data from next level", 32'(r_data), 32'(stub_data(line_of(10'h0C1, 0, 4))));
    chk("R9 no writeback into empty", 32'(d_wb), 32'd0);
    expect_line("R8 near fill", 0, 0, 4, 1'b1, 10'h0C1, stub_data(line_of(10'h0C1, 0, 4)));
    expect_line("R8 other line kept", 0, 2, 4, 1'b1, 10'h0C0, 16'h1111);
  endtask

  task automatic t_miss_far_wb();
    clear_banks();
    put(0, 3, 7, 10'h044, 16'h4444);
    run(mk(10'h045, 0, 7), 2'b01, 1'b1, 1'b1);
    chk("R7 pair miss latency", 32'(r_lat), 32'd2);
    chk("R9 farthest victim written back", 32'(d_wb), 32'd1);
    chk("R9 writeback address", 32'(wb_addr_seen), 32'(line_of(10'h044, 0, 7)));
    chk("R9 writeback data", 32'(wb_data_seen), 32'h4444);
    expect_line("R8 far fill", 0, 3, 7, 1'b1, 10'h045, stub_data(line_of(10'h045, 0, 7)));
    expect_line("R8 near left empty", 0, 0, 7, 1'b0, '0, '0);
  endtask

  task automatic t_miss_demote();
    clear_banks();
    put(0, 0, 1, 10'h055, 16'h5555);
    run(mk(10'h056, 0, 1), 2'b10, 1'b0, 1'b1);
    chk("R7 broadcast miss latency", 32'(r_lat), 32'd1);
    chk("R9 no writeback on demote", 32'(d_wb), 32'd0);
    expect_line("R9 victim demoted to pos1", 0, 1, 1, 1'b1, 10'h055, 16'h5555);
    expect_line("R8 near fill", 0, 0, 1, 1'b1, 10'h056, stub_data(line_of(10'h056, 0, 1)));
  endtask

  task automatic t_miss_near_wb();
    clear_banks();
    put(0, 0, 0, 10'h066, 16'h6666);
    run(mk(10'h067, 0, 0), 2'b00, 1'b0, 1'b0);
    chk("R9 demote off writes back", 32'(d_wb), 32'd1);
    chk("R9 writeback address", 32'(wb_addr_seen), 32'(line_of(10'h066, 0, 0)));
    expect_line("R9 pos1 not written", 0, 1, 0, 1'b0, '0, '0);
    clear_banks();
    put(0, 0, 0, 10'h077, 16'h7777);
    put(0, 1, 0, 10'h078, 16'h7878);
    run(mk(10'h079, 0, 0), 2'b00, 1'b0, 1'b1);
    chk("R9 blocked demote writes back", 32'(d_wb), 32'd1);
    chk("R9 blocked writeback data", 32'(wb_data_seen), 32'h7777);
    expect_line("R9 pos1 keeps its line", 0, 1, 0, 1'b1, 10'h078, 16'h7878);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_banks();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_seq_hit_swap();
    t_home_hit();
    t_pair_hit_empty();
    t_broadcast_set1();
    t_miss_near_empty();
    t_miss_far_wb();
    t_miss_demote();
    t_miss_near_wb();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule